// File: doc/BRIEF.md
# UART Interrupt Priority Encoder

This block chooses which of five interrupt sources a 16550-style serial port reports, and it drives the port's single interrupt request line. Each source is qualified by its own bit of a four-bit enable register. The character timeout is the exception: it has no enable bit of its own and uses the receive-data bit. Among the qualified sources a fixed chain keeps the most urgent one. The chain puts line errors first, then the character timeout, then received data, then transmitter-holding-empty, then modem status changes. The chosen source is turned into a four-bit identification code. Above that code sit two bits that show whether the FIFOs are enabled.

The block holds the enable register and a transmit-empty pending flag. The flag is a two-state machine with the states THRE_CLEAR and THRE_PENDING. It makes the transition THRE_CLEAR to THRE_PENDING on a pulse from the transmitter (`thre_event`), or when the enable register is written while the holding-empty status bit is set. It makes the transition THRE_PENDING to THRE_CLEAR only when the identification register is read while it reports the transmitter-empty code. If a set and a clear come in the same cycle, the set wins and the machine stays in THRE_PENDING.

The identification value is on `iir_rd_data` at all times. The read strobe `iir_rd_en` only triggers the clear-on-read side effect. The FIFOs, shift registers and baud timing live elsewhere and feed this block through its status inputs.

Top module: `uart_irq_arbiter`

## Requirements
- R1: After reset `ier_q` is 0, `iir_rd_data` is 0x01 while `fifo_en` is low, and `irq` is low.
- R2: When `ier_q[2]` is set and any of `lsr_in[4:1]` is set, the low nibble of `iir_rd_data` is 0x6. This source outranks all others.
- R3: When `ier_q[0]` is set and `rx_timeout_pend` is high, and R2 does not apply, the code is 0xC. With `ier_q[0]` clear the timeout is ignored.
- R4: When `ier_q[0]` is set and `lsr_in[0]` (data ready) is set, and either `fifo_en` is low or `rx_count >= rx_trig`, and R2 and R3 do not apply, the code is 0x4.
- R5: When `ier_q[1]` is set and the transmit-empty flag is pending, and R2 to R4 do not apply, the code is 0x2.
- R6: When `ier_q[3]` is set and any bit of `msr_delta` is set, and no higher source applies, the code is 0x0.
- R7: With no qualified source the code is 0x1. `irq` is high exactly when the code is not 0x1, in the same cycle.
- R8: `iir_rd_data[7:6]` are both 1 while `fifo_en` is high and both 0 otherwise. `iir_rd_data[5:4]` are always 0.
- R9: A write (`ier_wr_en`) stores `ier_wr_data[3:0]` into `ier_q` at the next clock edge. Bits 7:4 are dropped.
- R10: An enable write while `lsr_in[5]` (holding empty) is set makes the transmit-empty flag pending from the next edge. A write with `lsr_in[5]` clear does not set it.
- R11: A cycle with `iir_rd_en` high while the code is 0x2 clears the pending flag at the next edge. A read that reports any other code leaves the flag pending.
- R12: A `thre_event` pulse makes the flag pending at the next edge, even when a clearing read happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_wr_en | input | 1 | Enable register write strobe |
| ier_wr_data | input | 8 | Enable register write data |
| ier_q | output | 4 | Current enable register |
| iir_rd_en | input | 1 | Identification register read strobe |
| iir_rd_data | output | 8 | Identification register value |
| lsr_in | input | 6 | Line status: bit 0 data ready, bits 4:1 overrun/parity/framing/break, bit 5 holding empty |
| rx_timeout_pend | input | 1 | Character timeout pending |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trig | input | CNT_W | Receive FIFO trigger level |
| fifo_en | input | 1 | FIFOs enabled |
| msr_delta | input | 4 | Modem status change bits |
| thre_event | input | 1 | Pulse from the transmitter when the holding register empties |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are the ones that involve the pending flag, because the flag has no port of its own. It can only be seen through code 0x2, and code 0x2 only appears when every higher source is quiet. The bench therefore runs the full priority sweep twice. The first pass runs with the flag held in THRE_CLEAR. The second pass runs after a `thre_event` has put the flag in THRE_PENDING, and no read strobe is issued during the sweep, so the flag cannot leave that state. The clear-on-read cases are then staged with a line error masking the code during the read, and with a set pulse arriving in the same cycle as the read.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_SRC = 5;
    localparam int IER_W   = 4;

    // Line status bit positions
    localparam int LSR_DR   = 0;
    localparam int LSR_ERRL = 1;
    localparam int LSR_ERRH = 4;
    localparam int LSR_THRE = 5;

    // Enable register bit positions
    localparam int IE_RXDATA = 0;
    localparam int IE_THRE   = 1;
    localparam int IE_LINE   = 2;
    localparam int IE_MODEM  = 3;

    localparam logic [3:0] CODE_LINE   = 4'h6;
    localparam logic [3:0] CODE_TOUT   = 4'hC;
    localparam logic [3:0] CODE_RXDATA = 4'h4;
    localparam logic [3:0] CODE_THRE   = 4'h2;
    localparam logic [3:0] CODE_MODEM  = 4'h0;
    localparam logic [3:0] CODE_NONE   = 4'h1;

    // Index order is priority order: lower index wins
    typedef enum logic [2:0] {
        SRC_LINE   = 3'd0,
        SRC_TOUT   = 3'd1,
        SRC_RXDATA = 3'd2,
        SRC_THRE   = 3'd3,
        SRC_MODEM  = 3'd4,
        SRC_NONE   = 3'd5
    } irq_src_e;

    typedef enum logic {
        THRE_CLEAR   = 1'b0,
        THRE_PENDING = 1'b1
    } thre_state_e;

    function automatic logic [3:0] src_code(irq_src_e s);
        logic [3:0] c;
        unique case (s)
            SRC_LINE:   c = CODE_LINE;
            SRC_TOUT:   c = CODE_TOUT;
            SRC_RXDATA: c = CODE_RXDATA;
            SRC_THRE:   c = CODE_THRE;
            SRC_MODEM:  c = CODE_MODEM;
            default:    c = CODE_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/uart_irq_ier_reg.sv
module uart_irq_ier_reg
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic [IER_W-1:0] ier_q
);

    logic unused_hi;
    assign unused_hi = ^wr_data[7:IER_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ier_q <= '0;
        end else if (wr_en) begin
            ier_q <= wr_data[IER_W-1:0];
        end
    end

endmodule

// File: rtl/uart_irq_thre_fsm.sv
module uart_irq_thre_fsm
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic pend
);

    thre_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= THRE_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: a new set outranks a clearing read
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            THRE_CLEAR: begin
                if (set_req) begin
                    state_d = THRE_PENDING;
                end
            end
            THRE_PENDING: begin
                if (!set_req && clr_req) begin
                    state_d = THRE_CLEAR;
                end
            end
            default: state_d = THRE_CLEAR;
        endcase
    end

    always_comb begin
        pend = (state_q == THRE_PENDING);
    end

endmodule

// File: rtl/uart_irq_req.sv
module uart_irq_req
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [IER_W-1:0]   ier,
    input  logic [LSR_ERRH:0]  lsr,
    input  logic               tout_pend,
    input  logic               fifo_en,
    input  logic [CNT_W-1:0]   rx_count,
    input  logic [CNT_W-1:0]   rx_trig,
    input  logic               thre_pend,
    input  logic [3:0]         msr_delta,
    output logic [NUM_SRC-1:0] req
);

    logic any_err;
    logic level_met;

    always_comb begin
        any_err   = |lsr[LSR_ERRH:LSR_ERRL];
        level_met = !fifo_en || (rx_count >= rx_trig);
        req                  = '0;
        req[int'(SRC_LINE)]   = ier[IE_LINE] && any_err;
        req[int'(SRC_TOUT)]   = ier[IE_RXDATA] && tout_pend;
        req[int'(SRC_RXDATA)] = ier[IE_RXDATA] && lsr[LSR_DR] && level_met;
        req[int'(SRC_THRE)]   = ier[IE_THRE] && thre_pend;
        req[int'(SRC_MODEM)]  = ier[IE_MODEM] && (|msr_delta);
    end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] req,
    output irq_src_e           src
);

    logic [NUM_SRC-1:0] grant;

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_chain
            if (g == 0) begin : g_top
                assign grant[g] = req[g];
            end else begin : g_rest
                assign grant[g] = req[g] && !(|req[g-1:0]);
            end
        end
    endgenerate

    always_comb begin
        src = SRC_NONE;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant[i]) begin
                src = irq_src_e'(3'(i));
            end
        end
    end

endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_wr_en,
    input  logic [7:0]       ier_wr_data,
    output logic [IER_W-1:0] ier_q,
    input  logic             iir_rd_en,
    output logic [7:0]       iir_rd_data,
    input  logic [5:0]       lsr_in,
    input  logic             rx_timeout_pend,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             fifo_en,
    input  logic [3:0]       msr_delta,
    input  logic             thre_event,
    output logic             irq
);

    logic [NUM_SRC-1:0] req;
    irq_src_e           src;
    logic [3:0]         code;
    logic               thre_pend;
    logic               thre_set;
    logic               thre_clr;

    uart_irq_ier_reg u_ier (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ier_wr_en),
        .wr_data (ier_wr_data),
        .ier_q   (ier_q)
    );

    uart_irq_req #(.CNT_W(CNT_W)) u_req (
        .ier       (ier_q),
        .lsr       (lsr_in[LSR_ERRH:0]),
        .tout_pend (rx_timeout_pend),
        .fifo_en   (fifo_en),
        .rx_count  (rx_count),
        .rx_trig   (rx_trig),
        .thre_pend (thre_pend),
        .msr_delta (msr_delta),
        .req       (req)
    );

    uart_irq_prio u_prio (
        .req (req),
        .src (src)
    );

    always_comb begin
        thre_set = thre_event || (ier_wr_en && lsr_in[LSR_THRE]);
        thre_clr = iir_rd_en && (src == SRC_THRE);
    end

    uart_irq_thre_fsm u_thre (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (thre_set),
        .clr_req (thre_clr),
        .pend    (thre_pend)
    );

    always_comb begin
        code        = src_code(src);
        iir_rd_data = {fifo_en, fifo_en, 2'b00, code};
        irq         = (code != CODE_NONE);
    end

endmodule

// File: rtl/uart_irq_arbiter_chk.sv
module uart_irq_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ier_wr_en,
    input logic [7:0] ier_wr_data,
    input logic [3:0] ier_q,
    input logic       iir_rd_en,
    input logic [7:0] iir_rd_data,
    input logic [5:0] lsr_in,
    input logic       fifo_en,
    input logic       thre_event,
    input logic       thre_pend,
    input logic       irq
);

    // R9
    ier_keep_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ier_wr_en |=> ier_q == $past(ier_wr_data[3:0]));

    // R10
    ier_sets_thre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_wr_en && lsr_in[5]) |=> thre_pend);

    // R11
    thre_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd_en && iir_rd_data[3:0] == 4'h2 && !thre_event && !(ier_wr_en && lsr_in[5]))
        |=> !thre_pend);

    // R12
    thre_event_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thre_event |=> thre_pend);

    // R7
    irq_idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> iir_rd_data[3:0] == 4'h1);

    // R2
    line_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q[2] && |lsr_in[4:1]) |-> (iir_rd_data[3:0] == 4'h6 && irq));

    // R8
    fifo_hi_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iir_rd_data[5:4] == 2'b00 && iir_rd_data[7:6] == {fifo_en, fifo_en});

endmodule

bind uart_irq_arbiter uart_irq_arbiter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ier_wr_en   (ier_wr_en),
    .ier_wr_data (ier_wr_data),
    .ier_q       (ier_q),
    .iir_rd_en   (iir_rd_en),
    .iir_rd_data (iir_rd_data),
    .lsr_in      (lsr_in),
    .fifo_en     (fifo_en),
    .thre_event  (thre_event),
    .thre_pend   (thre_pend),
    .irq         (irq)
);

// File: tb/uart_irq_arbiter_tb.sv
module uart_irq_arbiter_tb;

    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ier_wr_en = 1'b0;
    logic [7:0]    ier_wr_data = '0;
    logic [3:0]    ier_q;
    logic          iir_rd_en = 1'b0;
    logic [7:0]    iir_rd_data;
    logic [5:0]    lsr_in = '0;
    logic          rx_timeout_pend = 1'b0;
    logic [CW-1:0] rx_count = '0;
    logic [CW-1:0] rx_trig = '0;
    logic          fifo_en = 1'b0;
    logic [3:0]    msr_delta = '0;
    logic          thre_event = 1'b0;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_irq_arbiter #(.FIFO_DEPTH(DEPTH)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .ier_wr_en       (ier_wr_en),
        .ier_wr_data     (ier_wr_data),
        .ier_q           (ier_q),
        .iir_rd_en       (iir_rd_en),
        .iir_rd_data     (iir_rd_data),
        .lsr_in          (lsr_in),
        .rx_timeout_pend (rx_timeout_pend),
        .rx_count        (rx_count),
        .rx_trig         (rx_trig),
        .fifo_en         (fifo_en),
        .msr_delta       (msr_delta),
        .thre_event      (thre_event),
        .irq             (irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_code(int ie, int lsr, int tout, int fen, int cnt, int trig,
                                    int pend, int msr);
        if ((ie & 4) != 0 && (lsr & 8'h1E) != 0) return 6;
        if ((ie & 1) != 0 && tout != 0) return 12;
        if ((ie & 1) != 0 && (lsr & 1) != 0 && (fen == 0 || cnt >= trig)) return 4;
        if ((ie & 2) != 0 && pend != 0) return 2;
        if ((ie & 8) != 0 && msr != 0) return 0;
        return 1;
    endfunction

    function automatic string tag_of(int code);
        case (code)
            6:  return "R2";
            12: return "R3";
            4:  return "R4";
            2:  return "R5";
            0:  return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic zero_inputs();
        lsr_in = '0; rx_timeout_pend = 0; rx_count = '0; rx_trig = '0;
        fifo_en = 0; msr_delta = '0;
    endtask

    task automatic write_ier(input logic [7:0] v, input bit thre_bit);
        @(negedge clk);
        ier_wr_data = v;
        ier_wr_en   = 1'b1;
        lsr_in[5]   = thre_bit;
        @(negedge clk);
        ier_wr_en   = 1'b0;
        lsr_in[5]   = 1'b0;
        #1;
    endtask

    task automatic pulse_read(input bit with_event);
        @(negedge clk);
        iir_rd_en  = 1'b1;
        thre_event = with_event;
        @(negedge clk);
        iir_rd_en  = 1'b0;
        thre_event = 1'b0;
        #1;
    endtask

    task automatic run_sweep(input int pend);
        for (int ie = 0; ie < 16; ie++) begin
            zero_inputs();
            write_ier(8'(ie), 1'b0);
            check(ier_q == 4'(ie), "R9 sweep write", int'(ier_q), ie);
            for (int lsr = 0; lsr < 32; lsr++)
            for (int tout = 0; tout < 2; tout++)
            for (int fen = 0; fen < 2; fen++)
            for (int md = 0; md < 2; md++)
            for (int cc = 0; cc < 3; cc++) begin
                @(negedge clk);
                lsr_in          = 6'(lsr);
                rx_timeout_pend = tout[0];
                fifo_en         = fen[0];
                msr_delta       = (md != 0) ? 4'b1000 : 4'b0000;
                rx_trig         = CW'(4);
                rx_count        = CW'(3 + cc);
                #2;
                begin
                    int ec;
                    int ei;
                    ec = exp_code(ie, lsr, tout, fen, 3 + cc, 4, pend, md);
                    ei = ec | ((fen != 0) ? 8'hC0 : 8'h00);
                    check(iir_rd_data[3:0] == 4'(ec), tag_of(ec), int'(iir_rd_data[3:0]), ec);
                    check(iir_rd_data[7:4] == 4'(ei >> 4), "R8 upper bits",
                          int'(iir_rd_data[7:4]), ei >> 4);
                    check(irq == (ec != 1), "R7 irq vs code", int'(irq), int'(ec != 1));
                end
            end
        end
        @(negedge clk);
        zero_inputs();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        check(ier_q == 4'h0, "R1 ier_q", int'(ier_q), 0);
        check(iir_rd_data == 8'h01, "R1 iir", int'(iir_rd_data), 1);
        check(irq == 1'b0, "R1 irq", int'(irq), 0);

        // R9: upper bits dropped
        write_ier(8'hF5, 1'b0);
        check(ier_q == 4'h5, "R9 low nibble", int'(ier_q), 5);

        // Pending clear: full sweep, R2-R8
        run_sweep(0);

        // R12: event sets pending
        @(negedge clk); thre_event = 1'b1;
        @(negedge clk); thre_event = 1'b0;
        write_ier(8'h02, 1'b0);
        check(iir_rd_data == 8'h02, "R12 event sets pending", int'(iir_rd_data), 2);

        // Pending set: full sweep again
        run_sweep(1);

        // R11: read reporting 0x2 clears pending
        write_ier(8'h0F, 1'b0);
        check(iir_rd_data == 8'h02, "R11 before read", int'(iir_rd_data), 2);
        pulse_read(1'b0);
        check(iir_rd_data == 8'h01, "R11 read clears", int'(iir_rd_data), 1);

        // R11: read reporting another code keeps pending
        @(negedge clk); thre_event = 1'b1;
        @(negedge clk); thre_event = 1'b0; lsr_in[1] = 1'b1;
        #1;
        check(iir_rd_data == 8'h06, "R11 masked by line status", int'(iir_rd_data), 6);
        pulse_read(1'b0);
        lsr_in[1] = 1'b0;
        #1;
        check(iir_rd_data == 8'h02, "R11 pending kept", int'(iir_rd_data), 2);

        // R12: set beats clear in the same cycle
        pulse_read(1'b1);
        check(iir_rd_data == 8'h02, "R12 set wins over clear", int'(iir_rd_data), 2);

        // R10: enable write with holding empty sets pending
        pulse_read(1'b0);
        check(iir_rd_data == 8'h01, "R10 cleared first", int'(iir_rd_data), 1);
        write_ier(8'h02, 1'b0);
        check(iir_rd_data == 8'h01, "R10 no set without holding empty", int'(iir_rd_data), 1);
        write_ier(8'h02, 1'b1);
        check(iir_rd_data == 8'h02, "R10 set on write", int'(iir_rd_data), 2);
        check(irq == 1'b1, "R10 irq", int'(irq), 1);

        // R3: timeout ignored without receive-data enable
        write_ier(8'h08, 1'b0);
        rx_timeout_pend = 1'b1;
        #1;
        check(iir_rd_data == 8'h01, "R3 timeout gated", int'(iir_rd_data), 1);
        rx_timeout_pend = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule